// File: doc/BRIEF.md
# Hardware Lock Bank

A bank of single-bit hardware locks on an APB-style slave port with a 32-bit data path. Processors that share a resource agree on a lock number. A processor takes the lock by reading that lock's word. The returned value says whether the lock was already held, and a read of a free lock marks it held in the same transfer. There is no separate compare-and-swap or write step, so two masters can never both see "free" for the same lock.

The owner releases a lock by writing zero to its word. A read-only status word shows the held state of every lock at once, and reading it changes nothing. A fixed identification word gives the number of locks. The port has no wait states. Every side effect is tied to the access phase of a transfer, so a transfer that stops after its setup phase leaves every lock untouched.

Top module: `hw_lock_bank`

## Requirements
- R1: After reset every lock is free, and the status word at offset 0x010 reads 0.
- R2: The identification word at offset 0x000 reads 0x00000020: the lock count in bits 7:0, with all other bits zero. Writes to it have no effect.
- R3: A read of lock n at byte offset 0x100 + 4*n, with n from 0 to 31, returns 0 when the lock is free. When that access phase completes, lock n is held.
- R4: A read of a held lock returns 0x00000001 and the lock stays held.
- R5: A write of 0x00000000 to lock n frees it at the end of the write's access phase.
- R6: A write of any non-zero value to a lock word changes no lock.
- R7: Bit n of the status word equals the held state of lock n. Reading the status word, or writing to it, changes no lock.
- R8: A setup phase (select high, enable low) changes no lock, however many cycles it lasts, if no access phase follows.
- R9: An access to any other offset, including an offset that is not word-aligned, reads 0xFFFFFFFF, raises pslverr_o in its access phase and changes no lock. Accesses to mapped offsets never raise pslverr_o.
- R10: An access to lock n never changes any other lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access-phase enable |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Always high: no wait states |
| pslverr_o | output | 1 | Error for an unmapped offset, in the access phase |

## Verification
The assertions assume that the bus follows the APB phase order. A setup phase either leads into a single access phase with the same address, direction and data, or is dropped. They also assume that psel_i and penable_i carry known values once reset is released. The bench drives every transfer through two tasks that hold the address, direction and data steady across both phases and lower select after each access. The only departure from that protocol is one deliberately abandoned setup phase, which is how R8 is tested.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
  localparam int unsigned OFF_SYS   = 'h000;
  localparam int unsigned OFF_STAT  = 'h010;
  localparam int unsigned OFF_LOCK0 = 'h100;

  typedef enum logic [1:0] {
    RGN_SYS  = 2'd0,
    RGN_STAT = 2'd1,
    RGN_LOCK = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/hlb_decode.sv
module hlb_decode import hlb_pkg::*; #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           rgn_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] LockLo = ADDR_W'(OFF_LOCK0);
  localparam logic [ADDR_W-1:0] LockHi = ADDR_W'(OFF_LOCK0 + 4 * NUM_LOCKS);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off   = addr_i - LockLo;
    idx_o = off[IDX_W+1:2];
    if (addr_i[1:0] != 2'b00)                       rgn_o = RGN_NONE;
    else if (addr_i == ADDR_W'(OFF_SYS))            rgn_o = RGN_SYS;
    else if (addr_i == ADDR_W'(OFF_STAT))           rgn_o = RGN_STAT;
    else if (addr_i >= LockLo && addr_i < LockHi)   rgn_o = RGN_LOCK;
    else                                            rgn_o = RGN_NONE;
  end
endmodule

// File: rtl/hlb_lock_cell.sv
module hlb_lock_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic claim_i,
  input  logic release_i,
  output logic held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        held_o <= 1'b0;
    else if (release_i) held_o <= 1'b0;
    else if (claim_i)   held_o <= 1'b1;
  end

  AST_CLAIM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i && !release_i |=> held_o);  // R3
  AST_RELEASE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !held_o);  // R5
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank import hlb_pkg::*; #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LOCKS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o
);
  localparam int unsigned IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

  region_e              rgn;
  logic [IDX_W-1:0]     idx;
  logic [NUM_LOCKS-1:0] held;
  logic [NUM_LOCKS-1:0] claim;
  logic [NUM_LOCKS-1:0] rel;
  logic                 access;
  logic                 lock_rd;
  logic                 lock_wr0;

  hlb_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_dec (
    .addr_i (paddr_i),
    .rgn_o  (rgn),
    .idx_o  (idx)
  );

  assign pready_o = 1'b1;
  // side effects only in the completing access phase
  assign access   = psel_i && penable_i && pready_o;
  assign lock_rd  = access && !pwrite_i && (rgn == RGN_LOCK);
  assign lock_wr0 = access &&  pwrite_i && (rgn == RGN_LOCK) && (pwdata_i == '0);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    assign claim[g] = lock_rd  && (idx == IDX_W'(g));
    assign rel[g]   = lock_wr0 && (idx == IDX_W'(g));
    hlb_lock_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .claim_i   (claim[g]),
      .release_i (rel[g]),
      .held_o    (held[g])
    );
  end

  always_comb begin
    prdata_o  = '0;
    pslverr_o = 1'b0;
    if (psel_i) begin
      unique case (rgn)
        RGN_SYS:  prdata_o = DATA_W'(NUM_LOCKS[7:0]);
        RGN_STAT: prdata_o = DATA_W'(held);
        RGN_LOCK: prdata_o = DATA_W'(held[idx]);
        default: begin
          prdata_o  = '1;
          pslverr_o = penable_i;
        end
      endcase
    end
  end

  AST_ERR_READS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> prdata_o == '1);  // R9
  AST_ERR_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access && rgn == RGN_NONE |=> $stable(held));  // R9
  AST_SETUP_NO_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !penable_i |=> $stable(held));  // R8
  AST_NONZERO_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access && pwrite_i && pwdata_i != '0 |=> $stable(held));  // R6
  AST_STAT_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access && rgn == RGN_STAT |=> $stable(held));  // R7
  AST_LOCK_RD_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access && rgn == RGN_LOCK |-> prdata_o[DATA_W-1:1] == '0 && !pslverr_o);  // R4
  AST_ONE_LOCK_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(held ^ $past(held)) <= 1);  // R10
endmodule

// File: tb/sim_hw_lock_bank.sv
module sim_hw_lock_bank;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] ref_held = '0;

  always #10 clk = ~clk;

  hw_lock_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr)
  );

  function automatic logic [11:0] lock_addr(int n);
    return 12'(32'h100 + 4 * n);
  endfunction

  function automatic logic [31:0] exp_lock_rd(int n);
    return {31'd0, ref_held[n]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #2; d = prdata; e = pslverr;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] v, output logic e);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
    @(negedge clk); penable = 1; #2; e = pslverr;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic chk_stat(string req);
    logic [31:0] d; logic e;
    apb_rd(12'h010, d, e);
    chk(req, d, ref_held);
    chk(req, {31'd0, e}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    int perm[N];
    logic [11:0] bad_addr[6] = '{12'h004, 12'h00C, 12'h014, 12'h101, 12'h180, 12'hFFC};
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk_stat("R1");
    chk("R1", {31'd0, pready}, 32'd1);
    // R2 identification word, write ignored
    apb_rd(12'h000, d, e); chk("R2", d, 32'h20); chk("R2", {31'd0, e}, 0);
    apb_wr(12'h000, 32'hFFFF_FFFF, e);
    apb_rd(12'h000, d, e); chk("R2", d, 32'h20);
    chk_stat("R2");

    // R3/R4 claims in random order
    for (int i = 0; i < N; i++) perm[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j = int'($urandom % (i + 1));
      int t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < N; i++) begin
      apb_rd(lock_addr(perm[i]), d, e);
      chk("R3", d, exp_lock_rd(perm[i])); ref_held[perm[i]] = 1'b1;
      apb_rd(lock_addr(perm[i]), d, e);
      chk("R4", d, exp_lock_rd(perm[i]));
      if (i % 4 == 3) chk_stat("R10");
    end
    chk_stat("R7");

    // R7 status write ignored
    apb_wr(12'h010, 32'h0, e);
    chk_stat("R7");

    // R6 non-zero writes ignored
    for (int i = 0; i < 8; i++) begin
      apb_wr(lock_addr(perm[i]), 32'h1 << (i * 4), e);
    end
    chk_stat("R6");

    // R5 release in random order
    for (int i = 0; i < N; i++) begin
      apb_wr(lock_addr(perm[N - 1 - i]), 32'h0, e);
      ref_held[perm[N - 1 - i]] = 1'b0;
      apb_rd(lock_addr(perm[N - 1 - i]), d, e);
      chk("R5", d, 32'd0); ref_held[perm[N - 1 - i]] = 1'b1;
      apb_wr(lock_addr(perm[N - 1 - i]), 32'h0, e);
      ref_held[perm[N - 1 - i]] = 1'b0;
      if (i % 8 == 7) chk_stat("R5");
    end

    // R8 abandoned setup phase
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = lock_addr(5);
    repeat (4) @(negedge clk);
    psel = 0;
    chk_stat("R8");
    apb_rd(lock_addr(5), d, e); chk("R8", d, 32'd0); ref_held[5] = 1'b1;

    // R9 unmapped offsets
    foreach (bad_addr[k]) begin
      apb_rd(bad_addr[k], d, e);
      chk("R9", d, 32'hFFFF_FFFF); chk("R9", {31'd0, e}, 32'd1);
      apb_wr(bad_addr[k], 32'h0, e);
      chk("R9", {31'd0, e}, 32'd1);
    end
    apb_wr(12'h104, 32'h0, e); ref_held[1] = 1'b0;
    chk_stat("R9");
    apb_rd(lock_addr(5), d, e); chk("R9", d, 32'd1);

    // random mix against the reference model
    for (int i = 0; i < 400; i++) begin
      int n = int'($urandom % N);
      int op = int'($urandom % 3);
      if (op == 0) begin
        apb_rd(lock_addr(n), d, e);
        chk("R3", d, exp_lock_rd(n)); ref_held[n] = 1'b1;
      end else if (op == 1) begin
        apb_wr(lock_addr(n), 32'h0, e); ref_held[n] = 1'b0;
      end else begin
        apb_wr(lock_addr(n), $urandom | 32'h1, e);
      end
      if (i % 10 == 9) chk_stat("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule